// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the execution datapath of an 8-bit accumulator machine. Each operation takes the accumulator, the auxiliary register B, one operand byte and the current carry, auxiliary-carry and overflow flags. It returns a new accumulator, a new B and updated flags. The operation set covers binary add, add with carry and subtract with borrow, increment and decrement, bytewise AND, OR, XOR and complement, the four rotates, nibble swap, BCD correction after an addition, and unsigned 8x8 multiply and 8/8 divide on the A:B pair.

All results go through one output register. When `strobe_i` is high at a rising clock edge, the register captures the outcome of the operation on the current inputs. Otherwise it keeps its contents. Operand fetch, register storage and instruction decoding are done by the surrounding core. That core feeds the registered flags back as the flag inputs of the next operation.

Top module: `acc_alu`

## Requirements
- R1: When `strobe_i` is high at a rising edge, every output takes the result of `op_i`. Without a strobe, all outputs keep their values. Reset drives all outputs to 0. Operation codes: ADD=0, ADDC=1, SUBB=2, INC=3, DEC=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RLC=10, RR=11, RRC=12, SWAP=13, DA=14, MUL=15, DIV=16. Codes 17 to 31 pass A, B, C, AC and OV through unchanged.
- R2: ADD computes A+operand. ADDC computes A+operand+C. The result goes to A. C is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the two's-complement result is outside -128..127.
- R3: SUBB computes A-operand-C into A. C is the borrow out of bit 7, AC is the borrow out of bit 3, and OV flags two's-complement overflow.
- R4: INC and DEC act on A and wrap (FFh+1 gives 00h, 00h-1 gives FFh). C, AC and OV are copied from their inputs.
- R5: AND, OR and XOR combine A with the operand, and CPL inverts A. All four copy C, AC and OV from their inputs.
- R6: RL moves bit 7 into bit 0 and RR moves bit 0 into bit 7; both leave the flags unchanged. RLC and RRC rotate through C as a ninth bit. SWAP exchanges the two nibbles of A and leaves the flags unchanged.
- R7: DA first adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble of that sum exceeds 9, when C is set, or when the first step carried out of bit 7. Applying the 60h correction sets C; otherwise C is kept. AC and OV are kept.
- R8: MUL places A*B with the low byte in A and the high byte in B. It clears C, sets OV exactly when the product exceeds FFh, and keeps AC.
- R9: DIV with B not zero places the quotient A/B in A and the remainder in B, and clears both C and OV.
- R10: DIV with B equal to zero sets OV, clears C, and leaves A and B unchanged.
- R11: P always equals the XOR of the eight bits of the registered A, so A and P together hold an even number of ones.
- R12: Every operation other than MUL and DIV copies `b_i` to `b_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Capture the result of this cycle's operation |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| b_i | input | 8 | B register operand |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Incoming carry / borrow |
| ac_i | input | 1 | Incoming auxiliary carry |
| ov_i | input | 1 | Incoming overflow |
| acc_o | output | 8 | Registered accumulator result |
| b_o | output | 8 | Registered B result |
| cy_o | output | 1 | Registered carry |
| ac_o | output | 1 | Registered auxiliary carry |
| ov_o | output | 1 | Registered overflow |
| p_o | output | 1 | Registered parity of acc_o |

## Verification
Within a single decimal-adjust operation, the low-nibble correction and the high-nibble correction can both fire. The carry produced by the first step must then trigger the second. Directed values such as 9Ah and FAh, and random accumulators paired with random C and AC, provoke this case. A bench model that applies the two steps in order judges the result, and the flags and the parity of the same result are checked in the same sample.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
    OP_DEC  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_CPL  = 5'd8,  OP_RL   = 5'd9,  OP_RLC  = 5'd10, OP_RR   = 5'd11,
    OP_RRC  = 5'd12, OP_SWAP = 5'd13, OP_DA   = 5'd14, OP_MUL  = 5'd15,
    OP_DIV  = 5'd16
  } op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } flg_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] opnd_i,
  input  flg_t          flg_i,
  output logic [DW-1:0] res_o,
  output flg_t          flg_o
);
  localparam int unsigned NW = DW / 2;
  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [DW-1:0] ONE     = DW'(1);
  localparam logic [DW:0]   LO_FIX  = (DW+1)'(6);
  localparam logic [DW-1:0] HI_FIX  = DW'(6) << NW;

  logic          add_cin;
  logic [DW:0]   add_s, sub_s, da_s1;
  logic [DW-1:0] da_s2;
  logic          da_hi;

  always_comb begin
    add_cin = (op_i == OP_ADDC) & flg_i.cy;
    add_s   = {1'b0, a_i} + {1'b0, opnd_i} + {{DW{1'b0}}, add_cin};
    sub_s   = {1'b0, a_i} - {1'b0, opnd_i} - {{DW{1'b0}}, flg_i.cy};
    // decimal adjust, low then high correction
    da_s1   = {1'b0, a_i};
    if (a_i[NW-1:0] > NIB_MAX || flg_i.ac) da_s1 = {1'b0, a_i} + LO_FIX;
    da_hi   = (da_s1[DW-1:NW] > NIB_MAX) || flg_i.cy || da_s1[DW];
    da_s2   = da_hi ? da_s1[DW-1:0] + HI_FIX : da_s1[DW-1:0];

    res_o = a_i;
    flg_o = flg_i;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        res_o    = add_s[DW-1:0];
        flg_o.cy = add_s[DW];
        flg_o.ac = a_i[NW] ^ opnd_i[NW] ^ add_s[NW];
        flg_o.ov = (a_i[DW-1] == opnd_i[DW-1]) && (add_s[DW-1] != a_i[DW-1]);
      end
      OP_SUBB: begin
        res_o    = sub_s[DW-1:0];
        flg_o.cy = sub_s[DW];
        flg_o.ac = a_i[NW] ^ opnd_i[NW] ^ sub_s[NW];
        flg_o.ov = (a_i[DW-1] != opnd_i[DW-1]) && (sub_s[DW-1] != a_i[DW-1]);
      end
      OP_INC: res_o = a_i + ONE;
      OP_DEC: res_o = a_i - ONE;
      OP_DA: begin
        res_o = da_s2;
        if (da_hi) flg_o.cy = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  localparam int unsigned NW = DW / 2;

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND:  res_o = a_i & opnd_i;
      OP_OR:   res_o = a_i | opnd_i;
      OP_XOR:  res_o = a_i ^ opnd_i;
      OP_CPL:  res_o = ~a_i;
      OP_RL:   res_o = {a_i[DW-2:0], a_i[DW-1]};
      OP_RR:   res_o = {a_i[0], a_i[DW-1:1]};
      OP_RLC: begin
        res_o = {a_i[DW-2:0], cy_i};
        cy_o  = a_i[DW-1];
      end
      OP_RRC: begin
        res_o = {cy_i, a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NW-1:0], a_i[DW-1:NW]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flg_t          flg_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output flg_t          flg_o
);
  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] prod;
  logic          b_zero;
  logic [DW-1:0] div_den;

  always_comb begin
    prod    = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
    b_zero  = (b_i == '0);
    div_den = b_zero ? DW'(1) : b_i;   // keep the divider defined on zero
    a_o     = a_i;
    b_o     = b_i;
    flg_o   = flg_i;
    case (op_i)
      OP_MUL: begin
        a_o      = prod[DW-1:0];
        b_o      = prod[PW-1:DW];
        flg_o.cy = 1'b0;
        flg_o.ov = |prod[PW-1:DW];
      end
      OP_DIV: begin
        flg_o.cy = 1'b0;
        flg_o.ov = b_zero;
        if (!b_zero) begin
          a_o = a_i / div_den;
          b_o = a_i % div_den;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          cy_i,
  input  logic          ac_i,
  input  logic          ov_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] b_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o,
  output logic          p_o
);
  op_e           op;
  flg_t          flg_in, ar_flg, md_flg, nxt_flg;
  logic [DW-1:0] ar_res, lg_res, md_a, md_b, nxt_a, nxt_b;
  logic          lg_cy;

  assign op     = op_e'(op_i);
  assign flg_in = '{cy: cy_i, ac: ac_i, ov: ov_i};

  acc_alu_arith #(.DW(DW)) u_arith (
    .op_i(op), .a_i(acc_i), .opnd_i(opnd_i), .flg_i(flg_in),
    .res_o(ar_res), .flg_o(ar_flg)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op_i(op), .a_i(acc_i), .opnd_i(opnd_i), .cy_i(cy_i),
    .res_o(lg_res), .cy_o(lg_cy)
  );

  acc_alu_muldiv #(.DW(DW)) u_muldiv (
    .op_i(op), .a_i(acc_i), .b_i(b_i), .flg_i(flg_in),
    .a_o(md_a), .b_o(md_b), .flg_o(md_flg)
  );

  always_comb begin
    nxt_a   = acc_i;
    nxt_b   = b_i;
    nxt_flg = flg_in;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB, OP_INC, OP_DEC, OP_DA: begin
        nxt_a   = ar_res;
        nxt_flg = ar_flg;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP: begin
        nxt_a      = lg_res;
        nxt_flg.cy = lg_cy;
      end
      OP_MUL, OP_DIV: begin
        nxt_a   = md_a;
        nxt_b   = md_b;
        nxt_flg = md_flg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      b_o   <= '0;
      cy_o  <= 1'b0;
      ac_o  <= 1'b0;
      ov_o  <= 1'b0;
      p_o   <= 1'b0;
    end else if (strobe_i) begin
      acc_o <= nxt_a;
      b_o   <= nxt_b;
      cy_o  <= nxt_flg.cy;
      ac_o  <= nxt_flg.ac;
      ov_o  <= nxt_flg.ov;
      p_o   <= ^nxt_a;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          strobe_i,
  input logic [4:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] b_i,
  input logic          cy_i,
  input logic          ac_i,
  input logic          ov_i,
  input logic [DW-1:0] acc_o,
  input logic [DW-1:0] b_o,
  input logic          cy_o,
  input logic          ac_o,
  input logic          ov_o,
  input logic          p_o
);
  logic is_incdec, is_lgc, is_md;
  assign is_incdec = (op_i == OP_INC) || (op_i == OP_DEC);
  assign is_lgc    = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_CPL);
  assign is_md     = (op_i == OP_MUL) || (op_i == OP_DIV);

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(acc_o) && $stable(b_o) && $stable({cy_o, ac_o, ov_o, p_o})); // R1

  AST_PARITY_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_o == ^acc_o); // R11

  AST_INCDEC_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && is_incdec |=> {cy_o, ac_o, ov_o} == $past({cy_i, ac_i, ov_i})); // R4

  AST_LOGIC_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && is_lgc |=> {cy_o, ac_o, ov_o} == $past({cy_i, ac_i, ov_i})); // R5

  AST_MUL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == OP_MUL |=> !cy_o && (ov_o == (b_o != '0)) && ac_o == $past(ac_i)); // R8

  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == OP_DIV && b_i == '0 |=>
      ov_o && !cy_o && acc_o == $past(acc_i) && b_o == $past(b_i)); // R10

  AST_B_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !is_md |=> b_o == $past(b_i)); // R12
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .op_i(op_i),
  .acc_i(acc_i), .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
  .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .p_o(p_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int WD_CYCLES = 100000;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic cy, ac, ov, p;
  } res_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, bq = '0, opnd = '0;
  logic       cy = 1'b0, ac = 1'b0, ov = 1'b0;
  logic [7:0] acc_q, b_q;
  logic       cy_q, ac_q, ov_q, p_q;

  int n_vec = 0, n_bad = 0, cyc = 0;
  res_t last;

  always #2 clk = ~clk;

  acc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .op_i(op),
    .acc_i(acc), .b_i(bq), .opnd_i(opnd), .cy_i(cy), .ac_i(ac), .ov_i(ov),
    .acc_o(acc_q), .b_o(b_q), .cy_o(cy_q), .ac_o(ac_q), .ov_o(ov_q), .p_o(p_q)
  );

  function automatic string req_of(int o);
    case (o)
      0, 1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5, 6, 7, 8: return "R5";
      9, 10, 11, 12, 13: return "R6";
      14: return "R7";
      15: return "R8";
      16: return "R9/R10";
      default: return "R1";
    endcase
  endfunction

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic res_t model(int o, int a, int b, int d, int c, int h, int v);
    int na = a, nb = b, ncy = c, nac = h, nov = v, s, ci, t, hi;
    case (o)
      0, 1: begin
        ci = (o == 1) ? c : 0;
        s = a + d + ci; na = s & 255; ncy = (s > 255);
        nac = (((a & 15) + (d & 15) + ci) > 15);
        s = sx(a) + sx(d) + ci; nov = (s > 127 || s < -128);
      end
      2: begin
        s = a - d - c; na = s & 255; ncy = (s < 0);
        nac = (((a & 15) - (d & 15) - c) < 0);
        s = sx(a) - sx(d) - c; nov = (s > 127 || s < -128);
      end
      3: na = (a + 1) & 255;
      4: na = (a + 255) & 255;
      5: na = a & d;
      6: na = a | d;
      7: na = a ^ d;
      8: na = (~a) & 255;
      9: na = ((a << 1) | (a >> 7)) & 255;
      10: begin na = ((a << 1) | c) & 255; ncy = a >> 7; end
      11: na = (a >> 1) | ((a & 1) << 7);
      12: begin na = (a >> 1) | (c << 7); ncy = a & 1; end
      13: na = ((a << 4) | (a >> 4)) & 255;
      14: begin
        t = a;
        if ((t & 15) > 9 || h) t = t + 6;
        hi = (t & 255) >> 4;
        if (hi > 9 || c || t > 255) begin t = (t & 255) + 'h60; ncy = 1; end
        na = t & 255;
      end
      15: begin s = a * b; na = s & 255; nb = s >> 8; ncy = 0; nov = (s > 255); end
      16: begin
        ncy = 0;
        if (b == 0) nov = 1;
        else begin na = a / b; nb = a % b; nov = 0; end
      end
      default: ;
    endcase
    model.a = 8'(na); model.b = 8'(nb);
    model.cy = ncy[0]; model.ac = nac[0]; model.ov = nov[0];
    model.p = ^model.a;
  endfunction

  task automatic compare(string tag, res_t e);
    n_vec++;
    if (acc_q !== e.a || b_q !== e.b || cy_q !== e.cy || ac_q !== e.ac ||
        ov_q !== e.ov || p_q !== e.p) begin
      n_bad++;
      $display("FAIL %s op=%0d act a=%h b=%h c%b ac%b ov%b p%b exp a=%h b=%h c%b ac%b ov%b p%b",
               tag, op, acc_q, b_q, cy_q, ac_q, ov_q, p_q, e.a, e.b, e.cy, e.ac, e.ov, e.p);
    end
  endtask

  // apply at a falling edge, capture at the next rising edge, compare at the following fall
  task automatic run(int o, int a, int b, int d, int c, int h, int v);
    res_t e;
    op = 5'(o); acc = 8'(a); bq = 8'(b); opnd = 8'(d);
    cy = c[0]; ac = h[0]; ov = v[0]; strobe = 1'b1;
    e = model(o, a, b, d, c, h, v);
    @(negedge clk);
    strobe = 1'b0;
    compare(req_of(o), e);
    last = e;
  endtask

  // R1: no strobe, new inputs must not reach the outputs
  task automatic idle_check();
    op = 5'($urandom_range(0, 16)); acc = 8'($urandom); bq = 8'($urandom);
    opnd = 8'($urandom); cy = 1'($urandom); ac = 1'($urandom); ov = 1'($urandom);
    @(negedge clk);
    compare("R1 hold", last);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_CYCLES) begin
      n_bad++;
      $display("FAIL R1 watchdog act=%0d cycles exp<%0d", cyc, WD_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    repeat (3) @(negedge clk);
    compare("R1 reset", '{a: 8'h00, b: 8'h00, cy: 1'b0, ac: 1'b0, ov: 1'b0, p: 1'b0});
    last = '0;
    rst_n = 1'b1;
    @(negedge clk);
    idle_check();                          // R1 after reset

    run(0, 'h7f, 'h11, 'h01, 0, 0, 0);     // R2 OV and AC
    run(0, 'hff, 'h22, 'h01, 0, 0, 0);     // R2 C wrap
    run(1, 'h10, 'h00, 'h20, 1, 0, 0);     // R2 ADDC uses C
    run(2, 'h00, 'h00, 'h00, 1, 0, 0);     // R3 borrow only
    run(2, 'h80, 'h00, 'h01, 0, 0, 0);     // R3 signed overflow
    run(3, 'hff, 'h00, 'h00, 1, 1, 1);     // R4 wrap up, flags kept
    run(4, 'h00, 'h00, 'h00, 0, 1, 0);     // R4 wrap down
    run(5, 'hf0, 'h33, 'h3c, 1, 0, 1);     // R5
    run(8, 'h5a, 'h00, 'h00, 0, 1, 1);     // R5 CPL
    run(10, 'h80, 'h00, 'h00, 0, 0, 0);    // R6 RLC
    run(12, 'h01, 'h00, 'h00, 1, 0, 0);    // R6 RRC
    run(13, 'h3c, 'h00, 'h00, 0, 0, 0);    // R6 SWAP
    run(14, 'h9a, 'h00, 'h00, 0, 0, 0);    // R7 both corrections
    run(14, 'hfa, 'h00, 'h00, 0, 0, 0);    // R7 low step carries out
    run(14, 'h12, 'h00, 'h00, 0, 1, 0);    // R7 AC only
    run(15, 'hff, 'hff, 'h00, 1, 0, 0);    // R8 max product
    run(15, 'h0f, 'h0f, 'h00, 1, 1, 1);    // R8 no overflow
    run(16, 'hff, 'h10, 'h00, 1, 0, 1);    // R9
    run(16, 'h37, 'h00, 'h00, 1, 0, 0);    // R10 divide by zero
    run(20, 'h55, 'h66, 'h77, 1, 1, 0);    // R1 unused code, R12
    idle_check();

    for (int i = 0; i < 3000; i++) begin   // R11 and R12 on every vector
      int o;
      o = ($urandom_range(0, 19) == 0) ? $urandom_range(17, 31) : $urandom_range(0, 16);
      run(o, $urandom_range(0, 255), ($urandom_range(0, 15) == 0) ? 0 : $urandom_range(0, 255),
          $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) idle_check();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule